// File: doc/BRIEF.md
# Dual Mode FSK Transmit Serializer

This block sits between a host that writes transmit bytes and an FSK modulator that wants one data bit per bit period. A byte written by the host lands in a single-entry holding register. At the next bit boundary with the shifter empty, the byte moves into a shift register and is sent one bit per bit period, least significant bit first. A free-running divider sets the bit period. With the default parameters it stands for 1200 bits per second from the system clock. The modulator receives each new bit together with a one-cycle valid strobe.

A mode input chooses how each byte goes out. In synchronous mode the eight data bits go out back-to-back, with nothing added. In asynchronous mode each byte becomes a ten-bit character: a low start bit, the eight data bits, then a high stop bit. A ready flag tells the host when the holding register can take another byte. Because the flag returns as soon as a byte enters the shifter, the host can refill during transmission and frames follow each other without gaps. When nothing is waiting at a bit boundary, the line rests at mark (1). In synchronous mode that idle bit is also reported as an underrun, because the receiver expects a continuous stream.

Top module: `fsk_tx_serializer`

## Requirements
- R1: `bit_strobe` is high for exactly one clock cycle per bit period, and consecutive strobes are exactly `CLK_DIV` clock cycles apart.
- R2: Data bits of a byte leave in order bit 0 first through bit 7 last, one per strobe.
- R3: With `async_mode` = 0 at the boundary where a byte is loaded, the frame is exactly the 8 data bits, with no start or stop bit.
- R4: With `async_mode` = 1 at the load boundary, the frame is 10 bits: a start bit of value 0, the 8 data bits, then a stop bit of value 1.
- R5: A write (`wr_en` high for one cycle) drives `tx_ready` low in the next cycle.
- R6: `tx_ready` returns high in the cycle the pending byte enters the shift register (the strobe cycle carrying its first bit). A byte written while the previous frame is shifting follows it with no idle bit between.
- R7: At a bit boundary with no frame in progress and no byte pending, `ser_bit` is 1 (mark).
- R8: `underrun` is 1 for an idle bit sent while `async_mode` = 0, is 0 for an idle bit in asynchronous mode, and is 0 for every frame bit. It changes only with a strobe.
- R9: The mode is captured when a byte is loaded; changing `async_mode` during a frame does not alter that frame.
- R10: While `rst` is high, `ser_bit` = 1, `tx_ready` = 1, `underrun` = 0 and `bit_strobe` = 0.
- R11: A second write while a byte is still pending replaces it; only the last written byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| async_mode | input | 1 | 0 = synchronous (unframed), 1 = asynchronous (start/stop framed) |
| ser_bit | output | 1 | Serial data bit toward the modulator |
| bit_strobe | output | 1 | One-cycle pulse marking a new `ser_bit` value |
| tx_ready | output | 1 | High when the holding register may be written |
| underrun | output | 1 | Set for an idle bit sent in synchronous mode |

## Verification
Directed phases come first. Idle periods in each mode show the mark level and the mode-dependent underrun flag. Continuous streams in each mode show unframed and framed character boundaries. A pair of writes in consecutive cycles shows that the last write wins. A mode toggle during an asynchronous frame shows that the mode is captured at load. Random writes with a fixed seed then land at every offset within the bit period, including the cycle of the load boundary itself, sometimes while a byte is already pending. This separates a design that loads at the boundary from one that misses a late write or lets it corrupt the frame in flight. A bench model replays every strobe and predicts the bit, the underrun flag and the ready flag.

// File: rtl/fsk_ser_pkg.sv
package fsk_ser_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 2;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic {
        MODE_SYNC  = 1'b0,
        MODE_ASYNC = 1'b1
    } tx_mode_e;

    // A frame is held lsb-first: bit 0 is the first bit on the line.
    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic frame_t build_frame(logic [DATA_W-1:0] data, tx_mode_e mode);
        frame_t f;
        if (mode == MODE_ASYNC) begin
            f.bits = {1'b1, data, 1'b0};
            f.len  = LEN_W'(FRAME_MAX);
        end else begin
            f.bits = {2'b11, data};
            f.len  = LEN_W'(DATA_W);
        end
        return f;
    endfunction

endpackage

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/fsk_tx_hold.sv
module fsk_tx_hold
    import fsk_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // A write in the same cycle as a take wins: the old byte leaves, the new one stays.
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/fsk_tx_shifter.sv
module fsk_tx_shifter
    import fsk_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  tx_mode_e          mode,
    output logic              take,
    output logic              ser_bit,
    output logic              bit_strobe,
    output logic              underrun
);
    logic [FRAME_MAX-1:0] shreg;
    logic [LEN_W-1:0]     remain;
    frame_t               next_frame;

    assign next_frame = build_frame(hold_data, mode);
    assign take       = tick && (remain == '0) && hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            remain     <= '0;
            ser_bit    <= 1'b1;
            bit_strobe <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            bit_strobe <= tick;
            if (tick) begin
                if (remain != '0) begin
                    ser_bit <= shreg[0];
                    shreg   <= shreg >> 1;
                    remain  <= remain - 1'b1;
                end else if (hold_full) begin
                    ser_bit  <= next_frame.bits[0];
                    shreg    <= next_frame.bits >> 1;
                    remain   <= next_frame.len - 1'b1;
                    underrun <= 1'b0;
                end else begin
                    ser_bit  <= 1'b1;
                    underrun <= (mode == MODE_SYNC);
                end
            end
        end
    end
endmodule

// File: rtl/fsk_tx_serializer.sv
module fsk_tx_serializer
    import fsk_ser_pkg::*;
#(
    parameter int CLK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              async_mode,
    output logic              ser_bit,
    output logic              bit_strobe,
    output logic              tx_ready,
    output logic              underrun
);
    logic              tick;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    tx_mode_e          mode;

    assign mode     = async_mode ? MODE_ASYNC : MODE_SYNC;
    assign tx_ready = ~hold_full;

    fsk_bit_timer #(.DIV(CLK_DIV)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fsk_tx_hold i_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    fsk_tx_shifter i_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .mode       (mode),
        .take       (take),
        .ser_bit    (ser_bit),
        .bit_strobe (bit_strobe),
        .underrun   (underrun)
    );
endmodule

// File: rtl/fsk_ser_checker.sv
module fsk_ser_checker #(
    parameter int CLK_DIV = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       async_mode,
    input logic       ser_bit,
    input logic       bit_strobe,
    input logic       tx_ready,
    input logic       underrun
);
    int   gap;
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (bit_strobe) begin
            gap  <= 0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1;
        end
    end

    // R1: strobes are evenly spaced by the divider
    a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && seen) |-> (gap == CLK_DIV - 1));

    // R1: a strobe lasts one cycle
    a_r1_strobe_single: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe);

    // R5: a write takes the ready flag down
    a_r5_ready_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_ready);

    // R1: the line only moves on a strobe
    a_r1_bit_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_strobe |-> $stable(ser_bit));

    // R8: underrun only moves on a strobe, and only during a mark bit
    a_r8_underrun_holds: assert property (@(posedge clk) disable iff (rst)
        !bit_strobe |-> $stable(underrun));

    a_r8_underrun_is_mark: assert property (@(posedge clk) disable iff (rst)
        underrun |-> ser_bit);

    // R8: an idle bit in asynchronous mode never raises underrun
    a_r8_async_idle: assert property (@(posedge clk) disable iff (rst)
        ($rose(underrun)) |-> !$past(async_mode));

    // R10: reset state
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (ser_bit && tx_ready && !underrun && !bit_strobe));
endmodule

bind fsk_tx_serializer fsk_ser_checker #(.CLK_DIV(CLK_DIV)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .async_mode (async_mode),
    .ser_bit    (ser_bit),
    .bit_strobe (bit_strobe),
    .tx_ready   (tx_ready),
    .underrun   (underrun)
);

// File: tb/test_fsk_tx_serializer.sv
module test_fsk_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       async_mode = 1'b1;
    logic       ser_bit, bit_strobe, tx_ready, underrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tx_serializer #(.CLK_DIV(DIV)) i_fsk_tx_serializer (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .async_mode (async_mode),
        .ser_bit    (ser_bit),
        .bit_strobe (bit_strobe),
        .tx_ready   (tx_ready),
        .underrun   (underrun)
    );

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Bench model
    bit         m_full = 1'b0;
    bit         m_over = 1'b0;
    logic [7:0] m_data = 8'h00;
    bit         p_we = 1'b0;
    logic [7:0] p_data = 8'h00;
    bit         p_mode = 1'b1;
    bit         f_mode = 1'b1;
    bit         exp_q[$];
    string      tag_q[$];
    int         gap = 0;
    bit         seen = 1'b0;
    int         cyc = 0;

    function automatic void load_frame(input logic [7:0] d, input bit amode, input bit over);
        if (amode) begin
            exp_q.push_back(1'b0);
            tag_q.push_back(over ? "R11" : "R4");
        end
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(d[i]);
            tag_q.push_back(over ? "R11" : (amode ? "R2" : "R3"));
        end
        if (amode) begin
            exp_q.push_back(1'b1);
            tag_q.push_back(over ? "R11" : "R4");
        end
    endfunction

    always @(negedge clk) begin
        if (running) begin
            cyc++;
            if (bit_strobe) begin
                if (seen) chk(gap == DIV - 1, "R1", gap, DIV - 1);
                seen = 1'b1;
                gap  = 0;
                if (exp_q.size() == 0 && m_full) begin
                    f_mode = p_mode;
                    load_frame(m_data, p_mode, m_over);
                    m_full = 1'b0;
                    m_over = 1'b0;
                end
                if (exp_q.size() > 0) begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (p_mode != f_mode) t = "R9";
                    chk(ser_bit == e, t, int'(ser_bit), int'(e));
                    chk(underrun == 1'b0, "R8", int'(underrun), 0);
                end else begin
                    chk(ser_bit == 1'b1, "R7", int'(ser_bit), 1);
                    chk(underrun == !p_mode, "R8", int'(underrun), int'(!p_mode));
                end
            end else begin
                gap++;
            end
            if (p_we) begin
                if (m_full) m_over = 1'b1;
                m_full = 1'b1;
                m_data = p_data;
            end
            chk(tx_ready == !m_full, p_we ? "R5" : "R6", int'(tx_ready), int'(!m_full));
            p_we   = wr_en;
            p_data = wr_data;
            p_mode = async_mode;
            if (cyc > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
                summary();
                $finish;
            end
        end
    end

    task automatic drive(input bit we, input logic [7:0] d, input bit m);
        @(posedge clk);
        #1;
        wr_en      = we;
        wr_data    = d;
        async_mode = m;
    endtask

    task automatic send(input logic [7:0] d, input bit m);
        while (!tx_ready) drive(1'b0, 8'h00, m);
        drive(1'b1, d, m);
        drive(1'b0, 8'h00, m);
    endtask

    initial begin
        bit mode;
        void'($urandom(32'h5eed_0605));
        @(negedge clk);
        chk(ser_bit == 1'b1, "R10", int'(ser_bit), 1);
        chk(tx_ready == 1'b1, "R10", int'(tx_ready), 1);
        chk(underrun == 1'b0, "R10", int'(underrun), 0);
        chk(bit_strobe == 1'b0, "R10", int'(bit_strobe), 0);
        repeat (2) @(posedge clk);
        #1;
        rst     = 1'b0;
        running = 1'b1;

        // R7/R8: idle in each mode
        repeat (3 * DIV) drive(1'b0, 8'h00, 1'b1);
        repeat (3 * DIV) drive(1'b0, 8'h00, 1'b0);

        // R3/R6: unframed stream
        send(8'hA5, 1'b0);
        for (int i = 0; i < 5; i++) send(8'(8'h11 * (i + 1)), 1'b0);

        // R4/R6: framed stream
        for (int i = 0; i < 6; i++) send(8'(8'h81 + i * 8'h17), 1'b1);

        // R11: overwrite a pending byte
        while (!tx_ready) drive(1'b0, 8'h00, 1'b1);
        drive(1'b1, 8'h3C, 1'b1);
        drive(1'b1, 8'hC3, 1'b1);
        drive(1'b0, 8'h00, 1'b1);
        repeat (24 * DIV) drive(1'b0, 8'h00, 1'b1);

        // R9: mode toggled while a framed byte is shifting
        send(8'h5A, 1'b1);
        while (!tx_ready) drive(1'b0, 8'h00, 1'b1);
        repeat (3 * DIV) drive(1'b0, 8'h00, 1'b0);
        repeat (12 * DIV) drive(1'b0, 8'h00, 1'b1);

        // Random traffic
        mode = 1'b1;
        for (int n = 0; n < 15000; n++) begin
            bit we;
            if ($urandom % 500 == 0) mode = ~mode;
            if (tx_ready) we = ($urandom % 4 == 0);
            else          we = ($urandom % 40 == 0);
            drive(we, 8'($urandom), mode);
        end
        repeat (22 * DIV) drive(1'b0, 8'h00, mode);

        running = 1'b0;
        summary();
        $finish;
    end
endmodule